// File: doc/BRIEF.md
# Cascadable Four-Channel Timer Bank

This block holds four 16-bit up-counters. Each counter has its own reload value and control byte, and all of them sit behind a small word-addressed register port. A channel counts one of four divided versions of the system clock. In cascade mode it counts the wrap-arounds of the channel just below it instead, so two or more channels can be joined into a wider counter or an event divider.

When a channel wraps past its all-ones value, it reloads from its reload register and, if allowed to, emits a one-cycle interrupt pulse on its own line. A wrap-around can step the next channel in the same clock cycle. That step can make the next channel wrap too, so a single edge can carry through several channels and can fire several interrupt lines together. The chain ends at the highest channel.

Software programs the reload value first, then writes the control byte with the run bit set. While the channel runs it can read the live count or change the divider.

Top module: `cascade_timer_bank`

## Requirements
- R1: After reset every count, reload and control value reads as 0 and no interrupt line is high.
- R2: bus_addr[3:2] selects the channel and bus_addr[1:0] the register. Offset 0 writes the reload value and reads the live count. Offset 1 reads and writes the control byte (bits 15:8 read as 0). Offsets 2 and 3 read as 0. Reads are combinational.
- R3: A control write that takes the run bit (bit 7) from 0 to 1 loads the count from the reload value at that clock edge.
- R4: A control write to a channel that is already running never reloads its count.
- R5: A running channel with the cascade bit (bit 2) clear advances by one every 1, 64, 256 or 1024 cycles for control bits 1:0 equal to 0, 1, 2 or 3.
- R6: A divider change written while the channel runs applies from the edge after that write.
- R7: A step taken at count 0xFFFF loads the reload value. A reload write leaves the live count unchanged and is used at the next start or wrap.
- R8: With control bit 6 set, a wrap drives tmr_irq[n] high for the one cycle in which the count shows the reload value. With bit 6 clear, the line stays low.
- R9: A channel with both the run bit and the cascade bit set ignores the divided clock and steps once for each wrap of the channel below. If either bit is clear, the lower channel's wraps do not step it.
- R10: Cascade steps carry through several channels at the same clock edge, and every channel that wraps pulses its interrupt in the same cycle.
- R11: A wrap of channel 3 steps nothing. Channel 0 in cascade mode never advances.
- R12: A channel whose run bit is clear holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Channel index (3:2) and register offset (1:0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| tmr_irq | output | 4 | Per-channel wrap interrupt pulses |

## Verification
Any write lands at the first rising edge after the write strobe, so a start load appears on the count at the next falling-edge sample. A wrap and its interrupt pulse appear together one edge after the count reads 0xFFFF. Each divider setting is checked by the gap between two successive count changes rather than by absolute cycle numbers, so the phase of the free-running base counter does not matter. The bench drives inputs on the falling edge, reads the combinational read port 1 ns later, and advances exactly one edge per expected register stage before each comparison.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W  = 8;
  localparam int PSC_W   = 10;
  localparam int BIT_RUN = 7;
  localparam int BIT_IE  = 6;
  localparam int BIT_CAS = 2;

  typedef enum logic [1:0] {
    PSC_DIV1    = 2'd0,
    PSC_DIV64   = 2'd1,
    PSC_DIV256  = 2'd2,
    PSC_DIV1024 = 2'd3
  } psc_sel_e;

  typedef enum logic [1:0] {
    OFS_COUNT = 2'd0,
    OFS_CTRL  = 2'd1,
    OFS_RSV2  = 2'd2,
    OFS_RSV3  = 2'd3
  } reg_ofs_e;

  // divided-clock tick for one selection: base counter low bits all ones
  function automatic logic psc_tick(input logic [PSC_W-1:0] base,
                                    input logic [1:0] sel);
    logic t;
    case (psc_sel_e'(sel))
      PSC_DIV1:   t = 1'b1;
      PSC_DIV64:  t = &base[5:0];
      PSC_DIV256: t = &base[7:0];
      default:    t = &base;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PSC_W-1:0] base_o
);
  logic [PSC_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_q + 1'b1;
  end

  assign base_o = base_q;
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int CNT_W   = 16
) (
  input  logic                            bus_wr,
  input  logic [$clog2(NUM_TMR)+1:0]      bus_addr,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   cnt_i,
  input  logic [NUM_TMR-1:0][CTRL_W-1:0]  ctl_i,
  output logic [NUM_TMR-1:0]              wr_rld_o,
  output logic [NUM_TMR-1:0]              wr_ctl_o,
  output logic [CNT_W-1:0]                rdata_o
);
  localparam int IDX_W = $clog2(NUM_TMR);

  logic [IDX_W-1:0] idx;
  reg_ofs_e         ofs;

  assign idx = bus_addr[IDX_W+1:2];
  assign ofs = reg_ofs_e'(bus_addr[1:0]);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_dec
    assign wr_rld_o[i] = bus_wr && (idx == IDX_W'(i)) && (ofs == OFS_COUNT);
    assign wr_ctl_o[i] = bus_wr && (idx == IDX_W'(i)) && (ofs == OFS_CTRL);
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (idx == IDX_W'(i)) begin
        case (ofs)
          OFS_COUNT: rdata_o = cnt_i[i];
          OFS_CTRL:  rdata_o = {{(CNT_W-CTRL_W){1'b0}}, ctl_i[i]};
          default:   rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PSC_W-1:0]  base_i,
  input  logic              wr_rld_i,
  input  logic              wr_ctl_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              carry_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  rld_o,
  output logic [CTRL_W-1:0] ctl_o,
  output logic              step_o,
  output logic              ovf_o,
  output logic              start_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  cnt_q, rld_q;
  logic [CTRL_W-1:0] ctl_q;
  logic              irq_q;
  logic              run, cas, tick;

  // next count: start load, wrap reload, or plain increment
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] rld,
                                                input logic load,
                                                input logic adv);
    logic [CNT_W-1:0] n;
    if (load)                n = rld;
    else if (adv && (&cur))  n = rld;
    else if (adv)            n = cur + 1'b1;
    else                     n = cur;
    return n;
  endfunction

  assign run     = ctl_q[BIT_RUN];
  assign cas     = ctl_q[BIT_CAS];
  assign tick    = psc_tick(base_i, ctl_q[1:0]);
  assign step_o  = run & (cas ? carry_i : tick);
  assign ovf_o   = step_o & (&cnt_q);
  assign start_o = wr_ctl_i & ~run & wdata_i[BIT_RUN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next(cnt_q, rld_q, start_o, step_o);
      irq_q <= ovf_o & ctl_q[BIT_IE];
      if (wr_rld_i) rld_q <= wdata_i;
      if (wr_ctl_i) ctl_q <= wdata_i[CTRL_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign ctl_o = ctl_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/cascade_timer_bank.sv
module cascade_timer_bank
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int CNT_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [$clog2(NUM_TMR)+1:0] bus_addr,
  input  logic [CNT_W-1:0]           bus_wdata,
  output logic [CNT_W-1:0]           bus_rdata,
  output logic [NUM_TMR-1:0]         tmr_irq
);
  logic [PSC_W-1:0]                 base;
  logic [NUM_TMR-1:0]               wr_rld, wr_ctl;
  logic [NUM_TMR-1:0][CNT_W-1:0]    cnt_w, rld_w;
  logic [NUM_TMR-1:0][CTRL_W-1:0]   ctl_w;
  logic [NUM_TMR-1:0]               step_w, ovf_w, start_w, carry_w;

  tmr_prescaler #(.PSC_W(PSC_W)) psc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .base_o (base)
  );

  tmr_regif #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) regif_i (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .cnt_i    (cnt_w),
    .ctl_i    (ctl_w),
    .wr_rld_o (wr_rld),
    .wr_ctl_o (wr_ctl),
    .rdata_o  (bus_rdata)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
    // the lowest channel has no source below it; the top one feeds nothing
    if (i == 0) begin : g_base
      assign carry_w[i] = 1'b0;
    end else begin : g_link
      assign carry_w[i] = ovf_w[i-1];
    end

    tmr_channel #(.CNT_W(CNT_W)) ch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .base_i   (base),
      .wr_rld_i (wr_rld[i]),
      .wr_ctl_i (wr_ctl[i]),
      .wdata_i  (bus_wdata),
      .carry_i  (carry_w[i]),
      .cnt_o    (cnt_w[i]),
      .rld_o    (rld_w[i]),
      .ctl_o    (ctl_w[i]),
      .step_o   (step_w[i]),
      .ovf_o    (ovf_w[i]),
      .start_o  (start_w[i]),
      .irq_o    (tmr_irq[i])
    );
  end
endmodule

// File: rtl/cascade_timer_bank_chk.sv
module cascade_timer_bank_chk
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int CNT_W   = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_TMR-1:0]             tmr_irq,
  input logic [NUM_TMR-1:0][CNT_W-1:0]  cnt_w,
  input logic [NUM_TMR-1:0][CNT_W-1:0]  rld_w,
  input logic [NUM_TMR-1:0][CTRL_W-1:0] ctl_w,
  input logic [NUM_TMR-1:0]             ovf_w,
  input logic [NUM_TMR-1:0]             start_w,
  input logic [NUM_TMR-1:0]             carry_w
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_a
    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      start_w[i] |=> cnt_w[i] == $past(rld_w[i])); // R3

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_w[i] |=> cnt_w[i] == $past(rld_w[i])); // R7

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_irq[i] |-> ($past(ovf_w[i]) && $past(ctl_w[i][BIT_IE]))); // R8

    AST_CASCADE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_w[i][BIT_RUN] && ctl_w[i][BIT_CAS] && !carry_w[i]) |=> $stable(cnt_w[i])); // R9

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_w[i][BIT_RUN] && !start_w[i]) |=> $stable(cnt_w[i])); // R12
  end
endmodule

bind cascade_timer_bank cascade_timer_bank_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .tmr_irq (tmr_irq),
  .cnt_w   (cnt_w),
  .rld_w   (rld_w),
  .ctl_w   (ctl_w),
  .ovf_w   (ovf_w),
  .start_w (start_w),
  .carry_w (carry_w)
);

// File: tb/cascade_timer_bank_tb_top.sv
`timescale 1ns/1ps
module cascade_timer_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  tmr_irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cascade_timer_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // write lands at the next rising edge; returns at the falling edge after it
  task automatic wr(input int ch, input int ofs, input logic [15:0] d);
    bus_addr = 4'((ch << 2) | ofs); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int ofs, output logic [15:0] v);
    bus_addr = 4'((ch << 2) | ofs);
    #1 v = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      rd(i, 0, v); check("R1 count", v, 16'h0);
      rd(i, 1, v); check("R1 ctrl", v, 16'h0);
    end
    check("R1 irq", {12'h0, tmr_irq}, 16'h0);
  endtask

  task automatic t_start_rewrite_stop();
    logic [15:0] v;
    do_reset();
    wr(0, 0, 16'h1000);
    rd(0, 0, v); check("R7 reload write keeps count", v, 16'h0);
    wr(0, 1, 16'h0080);
    rd(0, 0, v); check("R3 start load", v, 16'h1000);
    cyc(10);
    rd(0, 0, v); check("R5 div1 rate", v, 16'h100A);
    wr(0, 1, 16'h00C0);
    rd(0, 0, v); check("R4 no reload on rewrite", v, 16'h100B);
    rd(0, 1, v); check("R2 ctrl readback", v, 16'h00C0);
    rd(0, 2, v); check("R2 offset 2 reads zero", v, 16'h0);
    wr(0, 1, 16'h0000);
    rd(0, 0, v); check("R12 stop", v, 16'h100C);
    cyc(20);
    rd(0, 0, v); check("R12 hold", v, 16'h100C);
  endtask

  task automatic t_wrap_irq();
    logic [15:0] v;
    do_reset();
    wr(1, 0, 16'hFFFE);
    wr(1, 1, 16'h00C0);
    rd(1, 0, v); check("R3 start load", v, 16'hFFFE);
    wr(1, 0, 16'h1234);
    rd(1, 0, v); check("R7 count after reload write", v, 16'hFFFF);
    check("R8 irq idle", {12'h0, tmr_irq}, 16'h0);
    cyc(1);
    rd(1, 0, v); check("R7 wrap uses new reload", v, 16'h1234);
    check("R8 irq pulse", {12'h0, tmr_irq}, 16'h0002);
    cyc(1);
    rd(1, 0, v); check("R7 counts on", v, 16'h1235);
    check("R8 irq one cycle", {12'h0, tmr_irq}, 16'h0);
    wr(1, 1, 16'h0000);
    wr(1, 0, 16'hFFFF);
    wr(1, 1, 16'h0080);
    for (int k = 0; k < 4; k++) begin
      cyc(1);
      rd(1, 0, v); check("R7 wrap every cycle", v, 16'hFFFF);
      check("R8 no irq with bit6 clear", {12'h0, tmr_irq}, 16'h0);
    end
  endtask

  task automatic measure(input int ch, output int period, output logic [15:0] delta);
    logic [15:0] a, b;
    int n;
    rd(ch, 0, a); n = 0;
    do begin cyc(1); rd(ch, 0, b); n++; end while (b == a && n < 3000);
    a = b; n = 0;
    do begin cyc(1); rd(ch, 0, b); n++; end while (b == a && n < 3000);
    period = n; delta = b - a;
  endtask

  task automatic t_prescale();
    int p;
    logic [15:0] d, a, b;
    do_reset();
    wr(2, 1, 16'h0081);
    measure(2, p, d); check("R5 div64 period", 16'(p), 16'd64); check("R5 step size", d, 16'd1);
    wr(2, 1, 16'h0082);
    measure(2, p, d); check("R6 div256 period", 16'(p), 16'd256);
    wr(2, 1, 16'h0083);
    measure(2, p, d); check("R6 div1024 period", 16'(p), 16'd1024);
    wr(2, 1, 16'h0080);
    rd(2, 0, a); cyc(1); rd(2, 0, b);
    check("R6 div1 after switch", b, a + 16'd1);
    cyc(1); rd(2, 0, a);
    check("R6 div1 continues", a, b + 16'd1);
  endtask

  task automatic t_cascade_gate();
    logic [15:0] v, a;
    do_reset();
    wr(0, 0, 16'hFFFF);
    wr(1, 0, 16'h0010);
    wr(1, 1, 16'h0084);
    wr(2, 0, 16'h0020);
    wr(2, 1, 16'h0004);
    cyc(30);
    rd(1, 0, v); check("R9 cascade ignores clock", v, 16'h0010);
    wr(0, 1, 16'h0080);
    rd(1, 0, v); check("R9 no step at start edge", v, 16'h0010);
    cyc(6);
    rd(1, 0, v); check("R9 one step per lower wrap", v, 16'h0016);
    rd(2, 0, v); check("R9 stopped cascade not stepped", v, 16'h0000);
    wr(1, 1, 16'h0083);
    rd(1, 0, a);
    cyc(10);
    rd(1, 0, v);
    checks++;
    if ((v - a) > 16'd1) begin
      errors++;
      $display("FAIL R9 cascade-clear channel followed wraps: actual 0x%04h expected <= 0x%04h", v, a + 16'd1);
    end
  endtask

  task automatic t_ripple();
    logic [15:0] v;
    do_reset();
    wr(3, 0, 16'h7000); wr(3, 1, 16'h0084);
    wr(2, 0, 16'hFFFF); wr(2, 1, 16'h00C4);
    wr(1, 0, 16'hFFFF); wr(1, 1, 16'h00C4);
    wr(0, 0, 16'hFFFE); wr(0, 1, 16'h00C0);
    rd(0, 0, v); check("R3 start load", v, 16'hFFFE);
    cyc(1);
    rd(0, 0, v); check("R10 before ripple", v, 16'hFFFF);
    cyc(1);
    rd(3, 0, v); check("R10 top stepped same edge", v, 16'h7001);
    rd(1, 0, v); check("R10 middle reloaded", v, 16'hFFFF);
    check("R10 irq together", {12'h0, tmr_irq}, 16'h0007);
    cyc(1);
    check("R10 irq drops", {12'h0, tmr_irq}, 16'h0);
  endtask

  task automatic t_chain_end();
    logic [15:0] v;
    do_reset();
    wr(0, 0, 16'h0042); wr(0, 1, 16'h0084);
    wr(3, 0, 16'hFFFF); wr(3, 1, 16'h00C0);
    cyc(1);
    check("R11 top wraps with irq", {12'h0, tmr_irq}, 16'h0008);
    cyc(20);
    rd(0, 0, v); check("R11 no wrap-around to channel 0", v, 16'h0042);
  endtask

  initial begin
    t_reset();
    t_start_rewrite_stop();
    t_wrap_irq();
    t_prescale();
    t_cascade_gate();
    t_ripple();
    t_chain_end();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule